// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing controller of a 2 Kbyte serial memory that answers as a slave on an I2C bus. It oversamples the SCL and SDA lines with a fast system clock and recognises START and STOP conditions. It checks the device-type nibble of the first byte and turns the received bytes into write requests or memory reads. Acknowledge and data bits go back to the bus through a single open-drain pull-down enable.

Received data bytes go to an external write-buffer block through a one-cycle push strobe that carries the target address and the byte. When the host ends a write session, the block sends a commit strobe. While the buffer reports that its internal write is still running, the slave withholds its address acknowledge, so a host can poll for completion. Read data comes from a synchronous memory array through a read-enable and address port whose data returns one cycle after the enable. An 11-bit address pointer advances through the array as bytes are transferred.

Top module: `i2cmem_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and no push, commit or read strobe is active. Bus activity before the first START gets no acknowledge.
- R2: The first byte after a START is acknowledged (`sda_oe`=1 during the 9th SCL clock) only if its bits 7:4 equal 4'b1010. For any other value the slave answers NoACK and ignores the bus until the next START.
- R3: In a write-mode first byte (bit 0 = 0), bits 3:1 become address bits 10:8, and the following word-address byte supplies bits 7:0. In a read-mode first byte (bit 0 = 1), bits 3:1 are ignored.
- R4: In a write session every data byte is acknowledged and pushed once with its address. Between bytes only address bits 3:0 advance, and they wrap from 15 to 0 inside the same 16-byte page.
- R5: A STOP after at least one pushed data byte produces exactly one single-cycle `wbuf_commit`. A STOP with no data byte since the last START produces none.
- R6: While `wbuf_busy` is 1 the first byte gets NoACK. Once `wbuf_busy` is 0 the same byte is acknowledged.
- R7: A read-mode first byte with no word address returns the byte at the current pointer, which is the address after the last byte read or the address set by the last word address.
- R8: A write-mode first byte plus word address, followed by a repeated START and a read-mode first byte, returns the byte at the newly set address.
- R9: While the master acknowledges, the slave sends bytes at successive addresses. The address wraps from 0x7FF to 0x000 and is not held to a page.
- R10: A master NoACK followed by STOP leaves `sda_oe` at 0 and returns the slave to idle.
- R11: A STOP or START in the middle of a byte discards that partial byte: it is neither pushed nor acknowledged.
- R12: `sda_oe` is asserted only while SCL is low. Output bits change after SCL falls, and input bits are taken on SCL rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wbuf_busy | input | 1 | Internal write cycle in progress |
| wbuf_push | output | 1 | One-cycle strobe: store a data byte |
| wbuf_addr | output | 11 | Address of the pushed byte |
| wbuf_data | output | 8 | Pushed data byte |
| wbuf_commit | output | 1 | One-cycle strobe: program the buffered bytes |
| mem_rd_en | output | 1 | Read request to the memory array |
| mem_rd_addr | output | 11 | Read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |

## Verification
The assertions assume a well-formed bus. SCL and SDA never change in the same system cycle, SDA moves only while SCL is low except to form START or STOP, and no START or STOP occurs while the slave is pulling SDA low. They also assume that the read data port returns data one cycle after the enable. The bench master respects these rules: it waits four system cycles after every SCL fall before moving SDA, and it keeps each SCL phase at least ten cycles long. Because of that spacing, the two-stage synchronizer and the one-cycle memory latency always settle well before the next bus edge.

// File: rtl/i2cmem_pkg.sv
`timescale 1ns/1ps
package i2cmem_pkg;
    // Device-type nibble expected in bits 7:4 of the first byte
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Which byte of the transaction the engine is working on
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DEV   = 3'd1,
        PH_WORD  = 3'd2,
        PH_WDATA = 3'd3,
        PH_READ  = 3'd4
    } phase_e;
endpackage

// File: rtl/i2cmem_bus_sampler.sv
`timescale 1ns/1ps
// Synchronises both bus lines and derives edge and bus-condition pulses.
module i2cmem_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_c;
    logic [STAGES-1:0] sda_c;
    logic              scl_p;
    logic              sda_p;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_c <= '1;
                    sda_c <= '1;
                end else begin
                    scl_c <= {scl_c[STAGES-2:0], scl_i};
                    sda_c <= {sda_c[STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_c <= '1;
                    sda_c <= '1;
                end else begin
                    scl_c <= scl_i;
                    sda_c <= sda_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s    = scl_c[STAGES-1];
    assign sda_s    = sda_c[STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_p  = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_p   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cmem_ptr_step.sv
`timescale 1ns/1ps
// Next-address arithmetic: whole-array wrap for reads, in-page wrap for writes.
module i2cmem_ptr_step #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] seq_nx,
    output logic [ADDR_W-1:0] page_nx
);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    assign seq_nx = ptr + ONE_A;

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            assign page_nx = seq_nx;
        end else begin : g_paged
            localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);
            assign page_nx = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + ONE_P};
        end
    endgenerate
endmodule

// File: rtl/i2cmem_slave.sv
`timescale 1ns/1ps
module i2cmem_slave #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              wbuf_busy,
    output logic              wbuf_push,
    output logic [ADDR_W-1:0] wbuf_addr,
    output logic [7:0]        wbuf_data,
    output logic              wbuf_commit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data
);
    import i2cmem_pkg::*;

    // Address bits carried in the first byte (bits HI_W..1)
    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        phase_e            ph;
        phase_e            after;   // phase entered when the ack slot ends
        logic [3:0]        cnt;     // 0..8 data bits, 9 = ack slot
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic [HI_W-1:0]   hi;
        logic              wrote;
        logic              mack;
        logic              oe;
        logic              push;
        logic [ADDR_W-1:0] paddr;
        logic [7:0]        pdata;
        logic              commit;
        logic              rd_en;
        logic [ADDR_W-1:0] raddr;
        logic              rd_pend;
        logic [7:0]        rbuf;
    } eng_t;

    eng_t state_d, state_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [ADDR_W-1:0] seq_nx, page_nx;

    i2cmem_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    i2cmem_ptr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
        .ptr     (state_q.ptr),
        .seq_nx  (seq_nx),
        .page_nx (page_nx)
    );

    always_comb begin
        state_d         = state_q;
        state_d.push    = 1'b0;
        state_d.commit  = 1'b0;
        state_d.rd_en   = 1'b0;
        state_d.rd_pend = state_q.rd_en;
        if (state_q.rd_pend) begin
            state_d.rbuf = mem_rd_data;
        end

        if (start_p) begin
            state_d.ph    = PH_DEV;
            state_d.cnt   = 4'd0;
            state_d.oe    = 1'b0;
            state_d.wrote = 1'b0;
        end else if (stop_p) begin
            state_d.ph     = PH_IDLE;
            state_d.cnt    = 4'd0;
            state_d.oe     = 1'b0;
            state_d.commit = state_q.wrote;
            state_d.wrote  = 1'b0;
        end else begin
            case (state_q.ph)
                PH_DEV, PH_WORD, PH_WDATA: begin
                    if (scl_rise && state_q.cnt < 4'd8) begin
                        state_d.sh  = {state_q.sh[6:0], sda_s};
                        state_d.cnt = state_q.cnt + 4'd1;
                    end else if (scl_fall && state_q.cnt == 4'd8) begin
                        state_d.cnt = 4'd9;
                        if (state_q.ph == PH_DEV) begin
                            if (state_q.sh[7:4] == DEV_TYPE && !wbuf_busy) begin
                                state_d.oe = 1'b1;
                                if (state_q.sh[0]) begin
                                    state_d.after = PH_READ;
                                    state_d.rd_en = 1'b1;
                                    state_d.raddr = state_q.ptr;
                                end else begin
                                    state_d.after = PH_WORD;
                                    state_d.hi    = state_q.sh[HI_W:1];
                                end
                            end else begin
                                state_d.ph  = PH_IDLE;
                                state_d.cnt = 4'd0;
                            end
                        end else if (state_q.ph == PH_WORD) begin
                            state_d.oe    = 1'b1;
                            state_d.ptr   = {state_q.hi, state_q.sh};
                            state_d.after = PH_WDATA;
                        end else begin
                            state_d.oe    = 1'b1;
                            state_d.push  = 1'b1;
                            state_d.paddr = state_q.ptr;
                            state_d.pdata = state_q.sh;
                            state_d.ptr   = page_nx;
                            state_d.wrote = 1'b1;
                            state_d.after = PH_WDATA;
                        end
                    end else if (scl_fall && state_q.cnt == 4'd9) begin
                        state_d.cnt = 4'd0;
                        state_d.ph  = state_q.after;
                        if (state_q.after == PH_READ) begin
                            state_d.sh = state_q.rbuf;
                            state_d.oe = ~state_q.rbuf[7];
                        end else begin
                            state_d.oe = 1'b0;
                        end
                    end
                end
                PH_READ: begin
                    if (scl_rise && state_q.cnt < 4'd8) begin
                        state_d.cnt = state_q.cnt + 4'd1;
                    end else if (scl_rise && state_q.cnt == 4'd9) begin
                        state_d.mack = ~sda_s;
                    end else if (scl_fall && state_q.cnt >= 4'd1 && state_q.cnt <= 4'd7) begin
                        state_d.sh = {state_q.sh[6:0], 1'b0};
                        state_d.oe = ~state_q.sh[6];
                    end else if (scl_fall && state_q.cnt == 4'd8) begin
                        state_d.oe    = 1'b0;
                        state_d.cnt   = 4'd9;
                        state_d.rd_en = 1'b1;
                        state_d.raddr = seq_nx;
                        state_d.ptr   = seq_nx;
                    end else if (scl_fall && state_q.cnt == 4'd9) begin
                        state_d.cnt = 4'd0;
                        if (state_q.mack) begin
                            state_d.sh = state_q.rbuf;
                            state_d.oe = ~state_q.rbuf[7];
                        end else begin
                            state_d.ph = PH_IDLE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sda_oe      = state_q.oe;
    assign wbuf_push   = state_q.push;
    assign wbuf_addr   = state_q.paddr;
    assign wbuf_data   = state_q.pdata;
    assign wbuf_commit = state_q.commit;
    assign mem_rd_en   = state_q.rd_en;
    assign mem_rd_addr = state_q.raddr;
endmodule

// File: rtl/i2cmem_slave_chk.sv
`timescale 1ns/1ps
module i2cmem_slave_chk #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_oe,
    input logic              wbuf_push,
    input logic [ADDR_W-1:0] wbuf_addr,
    input logic              wbuf_commit
);
    logic                     scl_r, sda_r, have_q;
    logic [ADDR_W-PAGE_W-1:0] page_q;
    logic                     cond_raw;

    assign cond_raw = scl_i & scl_r & (sda_i ^ sda_r);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_r  <= 1'b1;
            sda_r  <= 1'b1;
            have_q <= 1'b0;
            page_q <= '0;
        end else begin
            scl_r <= scl_i;
            sda_r <= sda_i;
            if (cond_raw) begin
                have_q <= 1'b0;
            end else if (wbuf_push) begin
                have_q <= 1'b1;
                page_q <= wbuf_addr[ADDR_W-1:PAGE_W];
            end
        end
    end

    // R12: the pull-down only switches on while the bus clock is low
    assert_oe_rise_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R5: commit is a single-cycle strobe
    assert_commit_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wbuf_commit |=> !wbuf_commit);

    // R5: commit never coincides with a push
    assert_commit_not_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wbuf_commit |-> !wbuf_push);

    // R4: one push per received byte, never back to back
    assert_push_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wbuf_push |=> !wbuf_push);

    // R4: pushes within one session stay inside one page
    assert_push_same_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wbuf_push && have_q) |-> (wbuf_addr[ADDR_W-1:PAGE_W] == page_q));
endmodule

bind i2cmem_slave i2cmem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .sda_oe      (sda_oe),
    .wbuf_push   (wbuf_push),
    .wbuf_addr   (wbuf_addr),
    .wbuf_commit (wbuf_commit)
);

// File: tb/i2cmem_slave_tb.sv
`timescale 1ns/1ps
module i2cmem_slave_tb;
    localparam int H       = 10;
    localparam int BUSY_N  = 300;
    localparam int WD_CYC  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic        wbuf_busy = 1'b0;
    logic        wbuf_push;
    logic [10:0] wbuf_addr;
    logic [7:0]  wbuf_data;
    logic        wbuf_commit;
    logic        mem_rd_en;
    logic [10:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = 8'h00;

    logic [7:0]  mem  [0:2047];
    logic [7:0]  refm [0:2047];
    logic [18:0] pend_q [$];
    logic [18:0] exp_push [$];
    logic [7:0]  exp_rd [$];
    int          busy_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          n_commit = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2cmem_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .wbuf_busy   (wbuf_busy),
        .wbuf_push   (wbuf_push),
        .wbuf_addr   (wbuf_addr),
        .wbuf_data   (wbuf_data),
        .wbuf_commit (wbuf_commit),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data)
    );

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mem[i]  = 8'((i * 37) + (i >> 8));
            refm[i] = 8'((i * 37) + (i >> 8));
        end
    end

    // Memory array and write-buffer model
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (wbuf_push) pend_q.push_back({wbuf_addr, wbuf_data});
        if (wbuf_commit) begin
            while (pend_q.size() > 0) begin
                logic [18:0] e;
                e = pend_q.pop_front();
                mem[e[18:8]] = e[7:0];
            end
            wbuf_busy <= 1'b1;
            busy_cnt  = BUSY_N;
        end else if (busy_cnt > 0) begin
            busy_cnt = busy_cnt - 1;
            if (busy_cnt == 0) wbuf_busy <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Push monitor: compares every push against the scoreboard queue
    always @(negedge clk) begin
        if (wbuf_commit) n_commit++;
        if (wbuf_push) begin
            if (exp_push.size() == 0) begin
                check(1'b0, "R4 R11 unexpected push", {wbuf_addr, wbuf_data}, 0);
            end else begin
                logic [18:0] e;
                e = exp_push.pop_front();
                check({wbuf_addr, wbuf_data} == e, "R3 R4 push addr/data",
                      {wbuf_addr, wbuf_data}, e);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_n(H);
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        wait_n(4); sda_m = 1'b1; wait_n(H);
        scl_m = 1'b1; wait_n(H);
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(4); sda_m = 1'b0; wait_n(H);
        scl_m = 1'b1; wait_n(H);
        sda_m = 1'b1; wait_n(H);
    endtask

    task automatic send_bit(input bit b);
        wait_n(4); sda_m = b; wait_n(H);
        scl_m = 1'b1; wait_n(H);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        wait_n(4); sda_m = 1'b1; wait_n(H);
        scl_m = 1'b1; wait_n(H / 2);
        ack = ~sda_line;
        wait_n(H - H / 2);
        scl_m = 1'b0;
    endtask

    task automatic send_exp(input logic [7:0] b, input bit exp_ack, input string tag);
        bit a;
        send_byte(b, a);
        check(a == exp_ack, tag, a, exp_ack);
    endtask

    // Receives one byte and compares it with the head of the read scoreboard
    task automatic recv_byte(input bit give_ack, input string tag);
        logic [7:0] v;
        logic [7:0] e;
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wait_n(4); sda_m = 1'b1; wait_n(H);
            scl_m = 1'b1; wait_n(H / 2);
            v = {v[6:0], sda_line};
            wait_n(H - H / 2);
            scl_m = 1'b0;
        end
        wait_n(4); sda_m = ~give_ack; wait_n(H);
        scl_m = 1'b1; wait_n(H);
        scl_m = 1'b0;
        if (exp_rd.size() == 0) begin
            check(1'b0, tag, v, 0);
        end else begin
            e = exp_rd.pop_front();
            check(v == e, tag, v, e);
        end
    endtask

    task automatic wait_idle_buffer();
        wait_n(4);
        while (wbuf_busy) wait_n(1);
        wait_n(20);
    endtask

    initial begin
        int c0;
        wait_n(5);
        check(sda_oe == 1'b0 && wbuf_push == 1'b0 && wbuf_commit == 1'b0 && mem_rd_en == 1'b0,
              "R1 reset outputs", {sda_oe, wbuf_push, wbuf_commit, mem_rd_en}, 0);
        rst_n = 1'b1;
        wait_n(5);

        // R1: traffic with no START is ignored
        scl_m = 1'b0; wait_n(H);
        send_exp(8'hA0, 1'b0, "R1 no START no ack");
        bus_stop();

        // R2: wrong device type, then bytes ignored until START
        bus_start();
        send_exp(8'h50, 1'b0, "R2 wrong type nack");
        send_exp(8'hA0, 1'b0, "R2 ignored until START");
        bus_stop();

        // R3 R4 R5: page write with wrap at page end
        c0 = n_commit;
        exp_push.push_back({11'h32E, 8'h11});
        exp_push.push_back({11'h32F, 8'h22});
        exp_push.push_back({11'h320, 8'h33});
        bus_start();
        send_exp(8'hA6, 1'b1, "R2 device ack");
        send_exp(8'h2E, 1'b1, "R3 word address ack");
        send_exp(8'h11, 1'b1, "R4 data ack 0");
        send_exp(8'h22, 1'b1, "R4 data ack 1");
        send_exp(8'h33, 1'b1, "R4 data ack 2 page wrap");
        bus_stop();
        wait_n(4);
        refm[11'h32E] = 8'h11; refm[11'h32F] = 8'h22; refm[11'h320] = 8'h33;
        check(n_commit == c0 + 1, "R5 one commit after data", n_commit - c0, 1);
        check(exp_push.size() == 0, "R4 all pushes seen", exp_push.size(), 0);

        // R6: polling while busy
        bus_start();
        send_exp(8'hA0, 1'b0, "R6 nack while busy");
        bus_stop();
        wait_idle_buffer();
        c0 = n_commit;
        bus_start();
        send_exp(8'hA0, 1'b1, "R6 ack after busy");
        bus_stop();
        wait_n(4);
        check(n_commit == c0, "R5 no commit without data", n_commit - c0, 0);

        // R8 R9: random read then sequential across a page edge
        exp_rd.push_back(refm[11'h32E]);
        exp_rd.push_back(refm[11'h32F]);
        exp_rd.push_back(refm[11'h330]);
        bus_start();
        send_exp(8'hA6, 1'b1, "R8 dummy write ack");
        send_exp(8'h2E, 1'b1, "R8 word ack");
        bus_rstart();
        send_exp(8'hA1, 1'b1, "R8 read address ack");
        recv_byte(1'b1, "R8 random read data");
        recv_byte(1'b1, "R9 sequential data");
        recv_byte(1'b0, "R9 crosses page edge");
        bus_stop();
        check(sda_oe == 1'b0, "R10 released after NoACK STOP", sda_oe, 0);

        // R7: current address read
        exp_rd.push_back(refm[11'h331]);
        bus_start();
        send_exp(8'hA1, 1'b1, "R7 current read ack");
        recv_byte(1'b0, "R7 current address data");
        bus_stop();

        // R9: wrap at the end of the array; R3 read-mode bits ignored
        exp_rd.push_back(refm[11'h7FE]);
        exp_rd.push_back(refm[11'h7FF]);
        exp_rd.push_back(refm[11'h000]);
        bus_start();
        send_exp(8'hAE, 1'b1, "R3 high bits 111 ack");
        send_exp(8'hFE, 1'b1, "R9 word ack");
        bus_rstart();
        send_exp(8'hA1, 1'b1, "R3 read byte ack");
        recv_byte(1'b1, "R9 byte 7FE");
        recv_byte(1'b1, "R9 byte 7FF");
        recv_byte(1'b0, "R9 wrap to 000");
        bus_stop();
        check(sda_oe == 1'b0, "R10 idle after read", sda_oe, 0);

        // R11: STOP in the middle of a data byte
        c0 = n_commit;
        exp_push.push_back({11'h010, 8'h55});
        bus_start();
        send_exp(8'hA0, 1'b1, "R11 device ack");
        send_exp(8'h10, 1'b1, "R11 word ack");
        send_exp(8'h55, 1'b1, "R11 whole byte ack");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        wait_n(4);
        refm[11'h010] = 8'h55;
        check(n_commit == c0 + 1, "R11 commit for whole bytes only", n_commit - c0, 1);
        check(exp_push.size() == 0, "R11 partial byte not pushed", exp_push.size(), 0);
        wait_idle_buffer();

        exp_rd.push_back(refm[11'h010]);
        bus_start();
        send_exp(8'hA0, 1'b1, "R8 device ack");
        send_exp(8'h10, 1'b1, "R8 word ack");
        bus_rstart();
        send_exp(8'hA1, 1'b1, "R8 read ack");
        recv_byte(1'b0, "R11 committed byte read back");
        bus_stop();

        // R11: repeated START in the middle of a data byte
        c0 = n_commit;
        exp_rd.push_back(refm[11'h020]);
        bus_start();
        send_exp(8'hA0, 1'b1, "R11 device ack 2");
        send_exp(8'h20, 1'b1, "R11 word ack 2");
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_rstart();
        send_exp(8'hA1, 1'b1, "R11 read after abort ack");
        recv_byte(1'b0, "R11 abort left address 020");
        bus_stop();
        wait_n(4);
        check(n_commit == c0, "R5 no commit after aborted byte", n_commit - c0, 0);
        check(sda_oe == 1'b0, "R10 released at end", sda_oe, 0);

        wait_n(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule